// File: doc/BRIEF.md
# I2C Double-Buffered Data Register

This block sits between a processor bus and an I2C byte shifter, and holds the data register of the serial port. Transmit bytes pass through a small queue. Software can therefore place the next byte while the shifter is still sending the current one, and never has to hold the bus to wait for the shifter. Received bytes land in a holding register, and software can read it as often as it likes. Neither transmit nor receive accesses ever make the shifter wait: a byte request from the shifter is answered in the same cycle, whatever software is doing.

The queue allows only one pending byte until the shifter reports an address match. From that point it allows two, until the shifter reports the end of the frame. A room flag tells software when a further write will be accepted. A completion flag rises once per finished byte, in either direction. Any data access clears it, so at the end of a transmit frame software clears it with a dummy read instead of queuing more data. Writes that are refused and requests made to an empty queue leave sticky error flags. Software clears these by writing ones to them.

Top module: `i2cx_dual_buf`

## Requirements
- R1: After a synchronous active-low reset, `tx_room` is 1, and `xfer_done`, `err_ovf`, `err_unf` and `cpu_rdata` are all 0.
- R2: Queued bytes reach `sh_tx_byte` in the order they were written. While `sh_tx_req` is high, `sh_tx_byte` shows the oldest queued byte in that same cycle, and the clock edge removes it from the queue.
- R3: The queue capacity is 1 from reset or from `sh_frame_end`, and 2 from `sh_addr_match`. `tx_room` is 1 exactly when fewer bytes are queued than the capacity allows.
- R4: A data write while `tx_room` is 0 leaves the queued bytes unchanged and sets `err_ovf`, which stays set until it is cleared.
- R5: A request (`sh_tx_req`) while the queue is empty yields the byte 0xFF and sets the sticky `err_unf`.
- R6: A pulse on `flag_clr_en` clears `err_ovf` when `flag_clr_mask` bit 0 is 1, and clears `err_unf` when bit 1 is 1. A mask bit of 0 leaves its flag unchanged. A new error in the same cycle wins over the clear.
- R7: `xfer_done` is 1 in the cycle after `sh_byte_done` is sampled high, for transmitted and received bytes alike.
- R8: A data read (`cpu_rd_en`) or data write (`cpu_wr_en`) clears `xfer_done`, even a write that is refused. If `sh_byte_done` is high in the same cycle, the flag is set instead.
- R9: `sh_rx_stb` loads `sh_rx_byte` into `cpu_rdata` from the next cycle. Reads do not change `cpu_rdata`, so two reads during one byte time return the same byte.
- R10: A write and a shifter request in the same cycle are both served. The request receives the old head byte, and the written byte is queued behind the remaining bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr_en | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd_en | input | 1 | Data register read strobe |
| cpu_rdata | output | 8 | Last received byte |
| flag_clr_en | input | 1 | Error flag clear strobe |
| flag_clr_mask | input | 2 | Bit 0 clears overflow, bit 1 clears underrun |
| tx_room | output | 1 | Queue can accept another byte |
| xfer_done | output | 1 | Byte transfer complete flag |
| err_ovf | output | 1 | Sticky refused-write flag |
| err_unf | output | 1 | Sticky empty-request flag |
| sh_tx_req | input | 1 | Shifter takes the next transmit byte |
| sh_tx_byte | output | 8 | Byte handed to the shifter |
| sh_rx_stb | input | 1 | Shifter delivers a received byte |
| sh_rx_byte | input | 8 | Received byte |
| sh_byte_done | input | 1 | Shifter finished one byte |
| sh_addr_match | input | 1 | Address byte matched, frame started |
| sh_frame_end | input | 1 | Frame finished |

## Verification
A pointer or count that has gone wrong shows up on `sh_tx_byte` at the next request. The output is then a byte out of order, a repeated byte, or 0xFF where data was queued. It also shows up on `tx_room` one cycle after the write that should have filled or freed an entry. A wrong capacity state shows as `tx_room` staying high after one write before an address match, or falling after one write inside a frame. A wrong flag register is visible on `xfer_done`, `err_ovf` or `err_unf` one cycle after the event that sets or clears it. The bench exercises each of these events.

// File: rtl/i2cx_pkg.sv
// Shared definitions for the double-buffered I2C data register.
// Assumes an 8-bit data register and a two-bit error clear mask.
package i2cx_pkg;
    localparam int DATA_W      = 8;
    localparam int CLR_OVF_BIT = 0;
    localparam int CLR_UNF_BIT = 1;
    localparam int CLR_W       = 2;

    typedef struct packed {
        logic done;
        logic ovf;
        logic unf;
    } flag_t;
endpackage

// File: rtl/i2cx_txq.sv
// Transmit queue: a small circular buffer with a run-time capacity limit.
// Assumes cap never exceeds DEPTH. A pop of an empty queue shows FILL on
// the head and changes nothing; a push is taken only when there is room.
module i2cx_txq #(
    parameter int DW    = 8,
    parameter int DEPTH = 2,
    parameter logic [DW-1:0] FILL = '1,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          has_room,
    output logic          is_empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    // Decode accepted operations from occupancy
    always_comb begin
        is_empty = (count == '0);
        has_room = (count < cap);
        do_push  = push && has_room;
        do_pop   = pop && !is_empty;
        head     = is_empty ? FILL : mem[rptr];
    end

    // One storage register per entry, written when the write pointer selects it
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (do_push && (wptr == PW'(e)))
                mem[e] <= push_data;
        end
    end

    // Advance pointers with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    end

    // Occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (do_push && !do_pop)
            count <= count + 1'b1;
        else if (do_pop && !do_push)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/i2cx_flags.sv
// Status flags: transfer complete and the two sticky error flags.
// Assumes single-cycle event strobes. A set event wins over a clear in the
// same cycle, so no event is lost.
module i2cx_flags
    import i2cx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_done,
    input  logic             data_acc,
    input  logic             wr_refused,
    input  logic             req_empty,
    input  logic             clr_en,
    input  logic [CLR_W-1:0] clr_mask,
    output flag_t            flags
);
    // Update each flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (byte_done)
                flags.done <= 1'b1;
            else if (data_acc)
                flags.done <= 1'b0;

            if (wr_refused)
                flags.ovf <= 1'b1;
            else if (clr_en && clr_mask[CLR_OVF_BIT])
                flags.ovf <= 1'b0;

            if (req_empty)
                flags.unf <= 1'b1;
            else if (clr_en && clr_mask[CLR_UNF_BIT])
                flags.unf <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cx_rxhold.sv
// Receive holding register: captures the shifter's byte on its strobe.
// Assumes reads are non-destructive; only a new strobe changes the value.
module i2cx_rxhold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Capture a received byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/i2cx_dual_buf.sv
// Double-buffered I2C data register layer between CPU bus and byte shifter.
// Assumes the shifter pulses sh_tx_req once per byte it starts and expects
// sh_tx_byte in that same cycle. Capacity is PRE_DEPTH outside a matched
// frame and DEPTH inside one; CPU accesses never stall the shifter.
module i2cx_dual_buf
    import i2cx_pkg::*;
#(
    parameter int DEPTH     = 2,
    parameter int PRE_DEPTH = 1,
    parameter logic [DATA_W-1:0] FILL = '1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flag_clr_en,
    input  logic [CLR_W-1:0]  flag_clr_mask,
    output logic              tx_room,
    output logic              xfer_done,
    output logic              err_ovf,
    output logic              err_unf,
    input  logic              sh_tx_req,
    output logic [DATA_W-1:0] sh_tx_byte,
    input  logic              sh_rx_stb,
    input  logic [DATA_W-1:0] sh_rx_byte,
    input  logic              sh_byte_done,
    input  logic              sh_addr_match,
    input  logic              sh_frame_end
);
    logic          in_frame;
    logic [CW-1:0] q_cap;
    logic [CW-1:0] q_count;
    logic          q_empty;
    flag_t         flags;

    // Track whether the current frame has passed its address match
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_frame <= 1'b0;
        else if (sh_addr_match)
            in_frame <= 1'b1;
        else if (sh_frame_end)
            in_frame <= 1'b0;
    end

    // Select queue capacity from frame state
    always_comb q_cap = in_frame ? CW'(DEPTH) : CW'(PRE_DEPTH);

    i2cx_txq #(
        .DW    (DATA_W),
        .DEPTH (DEPTH),
        .FILL  (FILL)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cpu_wr_en),
        .push_data (cpu_wdata),
        .pop       (sh_tx_req),
        .cap       (q_cap),
        .head      (sh_tx_byte),
        .count     (q_count),
        .has_room  (tx_room),
        .is_empty  (q_empty)
    );

    i2cx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_done  (sh_byte_done),
        .data_acc   (cpu_wr_en || cpu_rd_en),
        .wr_refused (cpu_wr_en && !tx_room),
        .req_empty  (sh_tx_req && q_empty),
        .clr_en     (flag_clr_en),
        .clr_mask   (flag_clr_mask),
        .flags      (flags)
    );

    i2cx_rxhold #(.DW(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_rx_stb),
        .din   (sh_rx_byte),
        .dout  (cpu_rdata)
    );

    // Expose flag register fields
    always_comb begin
        xfer_done = flags.done;
        err_ovf   = flags.ovf;
        err_unf   = flags.unf;
    end
endmodule

// File: rtl/i2cx_dual_buf_chk.sv
// Property checker for the double-buffered I2C data register, bound to the top.
// Assumes the default 8-bit data path and a fill byte of all ones.
module i2cx_dual_buf_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr_en,
    input logic          cpu_rd_en,
    input logic [7:0]    cpu_rdata,
    input logic          tx_room,
    input logic          xfer_done,
    input logic          err_ovf,
    input logic          err_unf,
    input logic          sh_tx_req,
    input logic [7:0]    sh_tx_byte,
    input logic          sh_rx_stb,
    input logic [7:0]    sh_rx_byte,
    input logic          sh_byte_done,
    input logic [CW-1:0] q_count
);
    p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && tx_room && !sh_tx_req) |=> (q_count == CW'($past(q_count) + 1'b1)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovf) |-> $past(cpu_wr_en && !tx_room));

    p_fill_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_req && q_count == '0) |-> (sh_tx_byte == 8'hFF));

    p_underrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_req && q_count == '0) |=> err_unf);

    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sh_byte_done |=> xfer_done);

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_wr_en || cpu_rd_en) && !sh_byte_done) |=> !xfer_done);

    p_rx_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rx_stb |=> (cpu_rdata == $past(sh_rx_byte)));

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_rx_stb |=> $stable(cpu_rdata));
endmodule

bind i2cx_dual_buf i2cx_dual_buf_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_rd_en    (cpu_rd_en),
    .cpu_rdata    (cpu_rdata),
    .tx_room      (tx_room),
    .xfer_done    (xfer_done),
    .err_ovf      (err_ovf),
    .err_unf      (err_unf),
    .sh_tx_req    (sh_tx_req),
    .sh_tx_byte   (sh_tx_byte),
    .sh_rx_stb    (sh_rx_stb),
    .sh_rx_byte   (sh_rx_byte),
    .sh_byte_done (sh_byte_done),
    .q_count      (q_count)
);

// File: tb/sim_i2cx_dual_buf.sv
`timescale 1ns/1ps
// Self-checking bench for i2cx_dual_buf: a vector walk inside a matched
// frame, then directed tests for reset, capacity, errors, flags and receive.
module sim_i2cx_dual_buf;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_wr_en, cpu_rd_en, flag_clr_en;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic [1:0] flag_clr_mask;
    logic       tx_room, xfer_done, err_ovf, err_unf;
    logic       sh_tx_req, sh_rx_stb, sh_byte_done, sh_addr_match, sh_frame_end;
    logic [7:0] sh_tx_byte, sh_rx_byte;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    i2cx_dual_buf u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
        .cpu_rd_en(cpu_rd_en), .cpu_rdata(cpu_rdata),
        .flag_clr_en(flag_clr_en), .flag_clr_mask(flag_clr_mask),
        .tx_room(tx_room), .xfer_done(xfer_done),
        .err_ovf(err_ovf), .err_unf(err_unf),
        .sh_tx_req(sh_tx_req), .sh_tx_byte(sh_tx_byte),
        .sh_rx_stb(sh_rx_stb), .sh_rx_byte(sh_rx_byte),
        .sh_byte_done(sh_byte_done), .sh_addr_match(sh_addr_match),
        .sh_frame_end(sh_frame_end)
    );

    // Vector: {wr, wdata[7:0], req, exp_byte[7:0], exp_room, exp_unf}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 8'hA1, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 8'hB2, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b0, 8'h00, 1'b1, 8'hA1, 1'b1, 1'b0},
        {1'b1, 8'hC3, 1'b1, 8'hB2, 1'b1, 1'b0},
        {1'b0, 8'h00, 1'b1, 8'hC3, 1'b1, 1'b0},
        {1'b0, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1},
        {1'b1, 8'hD4, 1'b0, 8'h00, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b1, 8'hD4, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic idle();
        cpu_wr_en = 0; cpu_wdata = 0; cpu_rd_en = 0;
        flag_clr_en = 0; flag_clr_mask = 0;
        sh_tx_req = 0; sh_rx_stb = 0; sh_rx_byte = 0;
        sh_byte_done = 0; sh_addr_match = 0; sh_frame_end = 0;
    endtask

    // Advance one clock: inputs were set at a falling edge, return at the next
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 room", 8'(tx_room), 8'd1);
        chk("R1 done", 8'(xfer_done), 8'd0);
        chk("R1 ovf", 8'(err_ovf), 8'd0);
        chk("R1 unf", 8'(err_unf), 8'd0);
        chk("R1 rdata", cpu_rdata, 8'h00);

        // Arm the frame so capacity is two
        sh_addr_match = 1; tick();

        // R2 R10 R3 R5: vector walk
        for (int i = 0; i < NV; i++) begin
            cpu_wr_en = VEC[i][19];
            cpu_wdata = VEC[i][18:11];
            sh_tx_req = VEC[i][10];
            #1;
            if (VEC[i][10]) chk($sformatf("R2/R10 byte v%0d", i), sh_tx_byte, VEC[i][9:2]);
            tick();
            chk($sformatf("R3 room v%0d", i), 8'(tx_room), 8'(VEC[i][1]));
            chk($sformatf("R5 unf v%0d", i), 8'(err_unf), 8'(VEC[i][0]));
        end

        // R6: clearing the overflow bit only leaves underrun set
        flag_clr_en = 1; flag_clr_mask = 2'b01; tick();
        chk("R6 unf kept", 8'(err_unf), 8'd1);
        flag_clr_en = 1; flag_clr_mask = 2'b10; tick();
        chk("R6 unf cleared", 8'(err_unf), 8'd0);

        // R3 R4: capacity one before match; second write refused
        do_reset();
        cpu_wr_en = 1; cpu_wdata = 8'h11; tick();
        chk("R3 room pre-match", 8'(tx_room), 8'd0);
        cpu_wr_en = 1; cpu_wdata = 8'h22; tick();
        chk("R4 ovf set", 8'(err_ovf), 8'd1);
        sh_addr_match = 1; tick();
        chk("R3 room after match", 8'(tx_room), 8'd1);
        sh_tx_req = 1; #1;
        chk("R4 head kept", sh_tx_byte, 8'h11);
        tick();
        sh_tx_req = 1; #1;
        chk("R4 refused byte absent", sh_tx_byte, 8'hFF);
        tick();
        chk("R4 ovf sticky", 8'(err_ovf), 8'd1);
        // R6: set wins over clear in same cycle
        cpu_wr_en = 1; cpu_wdata = 8'h33; tick();
        cpu_wr_en = 1; cpu_wdata = 8'h44; tick();
        cpu_wr_en = 1; cpu_wdata = 8'h55;
        flag_clr_en = 1; flag_clr_mask = 2'b11; tick();
        chk("R6 set wins ovf", 8'(err_ovf), 8'd1);
        chk("R6 unf cleared both", 8'(err_unf), 8'd0);
        flag_clr_en = 1; flag_clr_mask = 2'b01; tick();
        chk("R6 ovf cleared", 8'(err_ovf), 8'd0);
        // R3: frame end drops capacity back to one
        sh_frame_end = 1; sh_tx_req = 1; tick();
        chk("R3 room after frame end", 8'(tx_room), 8'd0);

        // R7 R8: completion flag
        sh_byte_done = 1; tick();
        chk("R7 done set", 8'(xfer_done), 8'd1);
        tick();
        chk("R7 done holds", 8'(xfer_done), 8'd1);
        cpu_rd_en = 1; tick();
        chk("R8 read clears done", 8'(xfer_done), 8'd0);
        sh_byte_done = 1; tick();
        cpu_wr_en = 1; cpu_wdata = 8'h66; tick();
        chk("R8 refused write clears done", 8'(xfer_done), 8'd0);
        cpu_rd_en = 1; sh_byte_done = 1; tick();
        chk("R8 set wins", 8'(xfer_done), 8'd1);

        // R9: receive holding
        sh_rx_stb = 1; sh_rx_byte = 8'h5A; tick();
        chk("R9 rx loaded", cpu_rdata, 8'h5A);
        cpu_rd_en = 1; tick();
        chk("R9 first read", cpu_rdata, 8'h5A);
        cpu_rd_en = 1; tick();
        chk("R9 second read", cpu_rdata, 8'h5A);
        sh_rx_byte = 8'h77; tick();
        chk("R9 no strobe no load", cpu_rdata, 8'h5A);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule